// File: doc/BRIEF.md
# Processor Sleep and Wake Controller

This block decides when a small processor core may rest in a low-power state and when it must resume. The core reports three kinds of instruction by one-cycle strobes: wait-for-event, wait-for-interrupt and send-event. It also reports, by a fourth strobe, that an exception handler is returning to thread code. The interrupt controller supplies one pending bit and one enable bit per interrupt line. The block answers with a registered sleep flag, a deep-sleep flag, a one-cycle wake pulse and a one-cycle system reset request.

A one-bit event latch remembers an event that arrives while the core is not waiting for one. The next wait-for-event then completes at once instead of sleeping. A software-visible configuration word has three controls. The first lets every newly pending interrupt count as an event, even one that is disabled. The second selects deep sleep instead of ordinary sleep. The third sends the core back to sleep whenever a handler returns to thread code. A second address holds a write-only reset-request bit.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset, sleep_o, deep_o, wake_o and sys_reset_req_o are 0, the configuration word reads 0 and the event latch is clear.
- R2: With reg_sel=0, a write stores bit 4 (pending-as-event), bit 2 (deep sleep) and bit 1 (sleep on handler return), and a read returns them in the same positions. All other bits read 0 and ignore writes.
- R3: A write with reg_sel=1 and bit 2 set makes sys_reset_req_o 1 for exactly the cycle after the write. A write with bit 2 clear, or any write with reg_sel=0, gives no pulse. Reads with reg_sel=1 return 0.
- R4: When the core is awake and no enabled interrupt is pending, a wait-for-interrupt strobe sets sleep_o in the next cycle. That sleep ends only when some line is both pending and enabled. wake_o is then 1 for one cycle, and sleep_o falls in the cycle after the pulse.
- R5: A wait-for-event sleep ends on a send-event strobe, on any pending-and-enabled line, or, when pending-as-event is 1, on a 0-to-1 change of any pending bit, including a disabled line.
- R6: When pending-as-event is 0, a disabled line that becomes pending neither wakes a wait-for-event sleep nor sets the event latch.
- R7: A send-event strobe, or with pending-as-event set a new pending bit, sets the event latch when it arrives outside a wait-for-event sleep. A later wait-for-event finds the latch set, clears it and leaves sleep_o at 0.
- R8: deep_o equals the deep-sleep bit captured when sleep begins, holds that value for the whole sleep including the wake cycle, and is 0 when awake.
- R9: With sleep-on-return set, a handler-return strobe enters a sleep that ends like a wait-for-interrupt sleep. With the bit clear, the strobe has no effect.
- R10: A wait-for-interrupt sleep neither uses nor clears the event latch.
- R11: Instruction strobes that arrive during a sleep or during the wake cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register select: 0 configuration word, 1 reset-request word |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| wfe_stb | input | 1 | Wait-for-event executed |
| wfi_stb | input | 1 | Wait-for-interrupt executed |
| sev_stb | input | 1 | Send-event executed |
| exc_ret_stb | input | 1 | Handler returning to thread code |
| irq_pend | input | 8 | Pending bit per interrupt line |
| irq_en | input | 8 | Enable bit per interrupt line |
| sleep_o | output | 1 | Core is in a low-power state |
| deep_o | output | 1 | Low-power state is deep sleep |
| wake_o | output | 1 | One-cycle wake pulse |
| sys_reset_req_o | output | 1 | One-cycle system reset request |

## Verification
The configuration word is swept one bit position at a time, and with all ones and all zeros, so that any stored or leaking reserved bit shows up. Each of the two sleep kinds is tried against every wake source crossed with both settings of pending-as-event: a send-event, an enabled pending line and a disabled pending line. This separates the level wake on enabled lines, the edge-based event path and the rejection of disabled lines. Events are placed while awake, during a wait-for-interrupt sleep and during a wait-for-event sleep. A following wait-for-event then shows whether the latch was set, kept or consumed. Both deep settings and both sleep-on-return settings are used to check the mode flag and the return path.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int unsigned CFG_EOP_BIT  = 4;
  localparam int unsigned CFG_DEEP_BIT = 2;
  localparam int unsigned CFG_SOE_BIT  = 1;
  localparam int unsigned RST_REQ_BIT  = 2;

  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_WFE  = 2'd1,
    PS_WFI  = 2'd2,
    PS_WAKE = 2'd3
  } pstate_t;

  // Event source: explicit send-event, or any fresh pending bit when enabled.
  function automatic logic event_source(input logic sev, input logic any_rise,
                                        input logic eop);
    return sev | (eop & any_rise);
  endfunction

  // Packs configuration fields into read word positions.
  function automatic logic [31:0] pack_cfg(input logic eop, input logic deep,
                                           input logic soe);
    logic [31:0] w;
    w = '0;
    w[CFG_EOP_BIT]  = eop;
    w[CFG_DEEP_BIT] = deep;
    w[CFG_SOE_BIT]  = soe;
    return w;
  endfunction
endpackage

// File: rtl/swc_cfg_regs.sv
module swc_cfg_regs
  import swc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              eop,
  output logic              deep,
  output logic              soe,
  output logic              rst_req
);
  logic        cfg_wr;
  logic        rst_wr;
  logic [31:0] cfg_word;
  logic        unused_wdata;

  assign cfg_wr       = wr & ~sel;
  assign rst_wr       = wr & sel & wdata[RST_REQ_BIT];
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eop     <= 1'b0;
      deep    <= 1'b0;
      soe     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= rst_wr;
      if (cfg_wr) begin
        eop  <= wdata[CFG_EOP_BIT];
        deep <= wdata[CFG_DEEP_BIT];
        soe  <= wdata[CFG_SOE_BIT];
      end
    end
  end

  assign cfg_word = pack_cfg(eop, deep, soe);

  always_comb begin
    rdata = '0;
    if (!sel) rdata = cfg_word[DATA_W-1:0];
  end

  // R3: a reset pulse only follows a qualifying write
  p_rst_req_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(wr && sel && wdata[RST_REQ_BIT]));

  // R2: fields hold when no configuration write occurs
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && !sel) |=> $stable({eop, deep, soe}));
endmodule

// File: rtl/swc_irq_detect.sv
module swc_irq_detect #(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] pend,
  input  logic [NUM_IRQ-1:0] en,
  output logic               any_rise,
  output logic               any_en_pend
);
  logic [NUM_IRQ-1:0] pend_q;
  logic [NUM_IRQ-1:0] rise;
  logic [NUM_IRQ-1:0] en_pend;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= pend[i];
    end
    assign rise[i]    = pend[i] & ~pend_q[i];
    assign en_pend[i] = pend[i] & en[i];
  end

  assign any_rise    = |rise;
  assign any_en_pend = |en_pend;

  // R5: a detected rise means some bit was low last cycle
  p_rise_fresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_rise |-> ($countones(pend & ~$past(pend)) != 0));
endmodule

// File: rtl/swc_event_latch.sv
module swc_event_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (set) q <= 1'b1;
  end
endmodule

// File: rtl/swc_power_fsm.sv
module swc_power_fsm
  import swc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wfe_stb,
  input  logic wfi_stb,
  input  logic exc_ret_stb,
  input  logic soe,
  input  logic deep_cfg,
  input  logic evt_src,
  input  logic en_pend,
  input  logic latch_q,
  output logic latch_set,
  output logic latch_clr,
  output logic awake,
  output logic sleep_o,
  output logic deep_o,
  output logic wake_o
);
  pstate_t state, nxt;
  logic    consume;
  logic    deep_q;

  always_comb begin
    nxt     = state;
    consume = 1'b0;
    unique case (state)
      PS_RUN: begin
        if (wfe_stb) begin
          if (latch_q || evt_src) consume = 1'b1;
          else                    nxt = PS_WFE;
        end else if (wfi_stb) begin
          if (!en_pend) nxt = PS_WFI;
        end else if (exc_ret_stb && soe) begin
          if (!en_pend) nxt = PS_WFI;
        end
      end
      PS_WFE: begin
        if (evt_src || en_pend) begin
          nxt     = PS_WAKE;
          consume = evt_src;
        end
      end
      PS_WFI:  if (en_pend) nxt = PS_WAKE;
      PS_WAKE: nxt = PS_RUN;
      default: nxt = PS_RUN;
    endcase
  end

  assign latch_set = evt_src & ~consume;
  assign latch_clr = consume;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PS_RUN;
      deep_q <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt == PS_RUN)                          deep_q <= 1'b0;
      else if (state == PS_RUN && nxt != PS_RUN)  deep_q <= deep_cfg;
    end
  end

  assign awake   = (state == PS_RUN);
  assign sleep_o = (state != PS_RUN);
  assign wake_o  = (state == PS_WAKE);
  assign deep_o  = deep_q;

  // R4: the sleep flag drops right after the wake pulse
  p_wake_ends_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !sleep_o);

  // R4: a wait-for-interrupt sleep persists without an enabled pending line
  p_wfi_needs_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_WFI && !en_pend) |=> (state == PS_WFI));

  // R8: the mode flag is constant across a sleep
  p_deep_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_o && $past(sleep_o)) |-> $stable(deep_o));

  // R11: the wake cycle always returns to run regardless of strobes
  p_wake_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> awake);
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_sel,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               wfe_stb,
  input  logic               wfi_stb,
  input  logic               sev_stb,
  input  logic               exc_ret_stb,
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic [NUM_IRQ-1:0] irq_en,
  output logic               sleep_o,
  output logic               deep_o,
  output logic               wake_o,
  output logic               sys_reset_req_o
);
  logic cfg_eop, cfg_deep, cfg_soe;
  logic any_rise, any_en_pend;
  logic evt_src;
  logic latch_set, latch_clr, latch_q;
  logic awake;

  swc_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .sel(reg_sel), .wr(reg_wr), .wdata(reg_wdata),
    .rdata(reg_rdata), .eop(cfg_eop), .deep(cfg_deep), .soe(cfg_soe),
    .rst_req(sys_reset_req_o)
  );

  swc_irq_detect #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .pend(irq_pend), .en(irq_en),
    .any_rise(any_rise), .any_en_pend(any_en_pend)
  );

  assign evt_src = event_source(sev_stb, any_rise, cfg_eop);

  swc_event_latch u_latch (
    .clk(clk), .rst_n(rst_n), .set(latch_set), .clr(latch_clr), .q(latch_q)
  );

  swc_power_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wfe_stb(wfe_stb), .wfi_stb(wfi_stb),
    .exc_ret_stb(exc_ret_stb), .soe(cfg_soe), .deep_cfg(cfg_deep),
    .evt_src(evt_src), .en_pend(any_en_pend), .latch_q(latch_q),
    .latch_set(latch_set), .latch_clr(latch_clr), .awake(awake),
    .sleep_o(sleep_o), .deep_o(deep_o), .wake_o(wake_o)
  );

  // R7: a set latch makes wait-for-event return without sleeping
  p_consume_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && wfe_stb && latch_q) |=> (!sleep_o && !latch_q));

  // R6: with the option off, no disabled rise wakes a wait-for-event sleep
  p_eop_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_eop && sleep_o && !wake_o && !sev_stb && !any_en_pend && !$past(awake))
      |=> !wake_o);

  // R10: a wait-for-interrupt sleep keeps a set latch
  p_wfi_keeps_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && sleep_o) |=> latch_q);
endmodule

// File: tb/sim_sleep_wake_ctrl.sv
`timescale 1ns/1ps
module sim_sleep_wake_ctrl;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic reg_sel = 0, reg_wr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic wfe_stb = 0, wfi_stb = 0, sev_stb = 0, exc_ret_stb = 0;
  logic [N-1:0] irq_pend = 0, irq_en = 0;
  logic sleep_o, deep_o, wake_o, sys_reset_req_o;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sleep_wake_ctrl #(.NUM_IRQ(N), .DATA_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wfe_stb(wfe_stb),
    .wfi_stb(wfi_stb), .sev_stb(sev_stb), .exc_ret_stb(exc_ret_stb),
    .irq_pend(irq_pend), .irq_en(irq_en), .sleep_o(sleep_o), .deep_o(deep_o),
    .wake_o(wake_o), .sys_reset_req_o(sys_reset_req_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    reg_sel = sel; reg_wr = 1; reg_wdata = d; tick(); reg_wr = 0; reg_wdata = 0; reg_sel = 0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    reg_sel = sel; #1 d = reg_rdata; reg_sel = 0;
  endtask

  task automatic do_wfe(); wfe_stb = 1; tick(); wfe_stb = 0; endtask
  task automatic do_wfi(); wfi_stb = 1; tick(); wfi_stb = 0; endtask

  task automatic wake_by_sev(input string req);
    sev_stb = 1; tick(); sev_stb = 0;
    chk(req, {30'd0, wake_o, sleep_o}, 32'h3);
    tick();
    chk(req, {30'd0, wake_o, sleep_o}, 32'h0);
  endtask

  task automatic quiet(); irq_pend = 0; irq_en = 0; tick(); tick(); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    tick(); tick(); rst_n = 1; tick();
    // R1 reset state
    chk("R1 outputs", {28'd0, sleep_o, deep_o, wake_o, sys_reset_req_o}, 0);
    rd(0, v); chk("R1 cfg", v, 0);
    do_wfe(); chk("R1 latch clear", {31'd0, sleep_o}, 1);
    wake_by_sev("R1 wake");

    // R2 bit sweep
    for (int b = 0; b < 32; b++) begin
      wr(0, 32'h1 << b);
      chk("R3 no pulse on cfg write", {31'd0, sys_reset_req_o}, 0);
      rd(0, v); chk("R2 sweep", v, (32'h1 << b) & 32'h16);
    end
    wr(0, 32'hFFFF_FFFF); rd(0, v); chk("R2 all ones", v, 32'h16);
    wr(0, 32'h0); rd(0, v); chk("R2 zero", v, 0);

    // R3 reset request
    wr(1, 32'h4); chk("R3 pulse", {31'd0, sys_reset_req_o}, 1);
    tick(); chk("R3 one cycle", {31'd0, sys_reset_req_o}, 0);
    wr(1, 32'hFFFF_FFFB); chk("R3 zero bit no pulse", {31'd0, sys_reset_req_o}, 0);
    rd(1, v); chk("R3 reads zero", v, 0);
    rd(0, v); chk("R3 cfg untouched", v, 0);

    // R4 R8 R10 R11 wait-for-interrupt sweep over deep setting
    for (int d = 0; d < 2; d++) begin
      wr(0, d << 2);
      do_wfi();
      chk("R4 sleep entry", {31'd0, sleep_o}, 1);
      chk("R8 deep", {31'd0, deep_o}, d);
      irq_pend[3] = 1; tick(); tick();
      chk("R4 disabled no wake", {30'd0, wake_o, sleep_o}, 32'h1);
      sev_stb = 1; tick(); sev_stb = 0; tick();
      chk("R4 sev no wake", {30'd0, wake_o, sleep_o}, 32'h1);
      wfe_stb = 1; tick(); wfe_stb = 0; exc_ret_stb = 1; tick(); exc_ret_stb = 0;
      chk("R11 strobes ignored", {30'd0, wake_o, sleep_o}, 32'h1);
      chk("R8 deep held", {31'd0, deep_o}, d);
      irq_en[3] = 1; tick();
      chk("R4 wake pulse", {30'd0, wake_o, sleep_o}, 32'h3);
      chk("R8 deep in wake", {31'd0, deep_o}, d);
      wfi_stb = 1; tick(); wfi_stb = 0;
      chk("R4 awake after", {29'd0, deep_o, wake_o, sleep_o}, 32'h0);
      chk("R11 wfi in wake ignored", {31'd0, sleep_o}, 0);
      quiet();
      do_wfe(); chk("R10 latch kept", {31'd0, sleep_o}, 0);
      do_wfe(); chk("R7 latch consumed", {31'd0, sleep_o}, 1);
      wake_by_sev("R5 sev wakes");
    end

    // R5 R6 wait-for-event sweep: option x trigger
    for (int e = 0; e < 2; e++) begin
      for (int t = 0; t < 3; t++) begin
        logic exp_w;
        wr(0, e << 4);
        do_wfe(); chk("R5 wfe sleep", {31'd0, sleep_o}, 1);
        exp_w = (t != 2) || (e == 1);
        if (t == 0) sev_stb = 1;
        else begin irq_pend[5] = 1; irq_en[5] = (t == 1); end
        tick(); sev_stb = 0;
        chk(exp_w ? "R5 wake" : "R6 no wake", {31'd0, wake_o}, exp_w);
        tick();
        if (exp_w) chk("R5 awake", {31'd0, sleep_o}, 0);
        else begin
          chk("R6 still asleep", {31'd0, sleep_o}, 1);
          wake_by_sev("R6 sev wake");
        end
        quiet();
        do_wfe(); chk("R6 latch not set", {31'd0, sleep_o}, 1);
        wake_by_sev("R5 cleanup");
      end
    end

    // R7 events while awake
    wr(0, 32'h0);
    sev_stb = 1; tick(); sev_stb = 0;
    do_wfe(); chk("R7 sev latched", {31'd0, sleep_o}, 0);
    irq_pend[1] = 1; tick(); quiet();
    do_wfe(); chk("R6 disabled rise not latched", {31'd0, sleep_o}, 1);
    wake_by_sev("R6 wake");
    wr(0, 32'h10);
    irq_pend[1] = 1; tick(); quiet();
    do_wfe(); chk("R7 rise latched", {31'd0, sleep_o}, 0);
    do_wfe(); chk("R7 cleared", {31'd0, sleep_o}, 1);
    wake_by_sev("R7 wake");

    // R9 sleep on handler return
    wr(0, 32'h2);
    exc_ret_stb = 1; tick(); exc_ret_stb = 0;
    chk("R9 return sleeps", {31'd0, sleep_o}, 1);
    sev_stb = 1; tick(); sev_stb = 0; tick();
    chk("R9 sev no wake", {31'd0, sleep_o}, 1);
    irq_pend[0] = 1; irq_en[0] = 1; tick();
    chk("R9 irq wake", {31'd0, wake_o}, 1);
    tick(); quiet();
    wr(0, 32'h0);
    exc_ret_stb = 1; tick(); exc_ret_stb = 0;
    chk("R9 off no sleep", {31'd0, sleep_o}, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule